// File: doc/BRIEF.md
# Boundary-Scan I/O Cell Register

This block is the boundary-scan data register that sits between a chip's core and its pads. Each pad has three cells on the serial path: output-enable, output and input. One more cell watches the external reset pin. On Capture-DR the register loads the live values. The output and output-enable cells take the core's values, the input cells take the pad values, and the reset cell takes the reset pin level. During Shift-DR the chain moves one place toward the serial output on every rising TCK edge. On Update-DR the shifted values move into a separate bank of hold registers.

The instruction decoder drives a two-bit mode. The normal/sample-preload modes leave the core in charge of the pads. The external-test mode drives the pads from the held output and output-enable values. The internal-test mode feeds the core's inputs from the held input-cell values. Both test modes use whatever was last loaded into the hold registers. The reset cell can only be observed: the reset reaching the core is always the pin itself. The TAP state machine and the instruction register are outside this block.

Top module: `bscan_chain_top`

## Requirements
- R1: While `trst_n` is low, every chain cell and every update stage is 0, so `tdo` is 0 and all pads and core inputs follow the normal path.
- R2: Chain positions count from the `tdi` end, starting at 0. Pad k uses position 3k for output-enable, 3k+1 for output and 3k+2 for input. The reset cell is at position 3·NPAD, and `tdo` shows that last position.
- R3: When `shift_dr` is high at a rising `tck` edge, every cell takes the value of its neighbour on the `tdi` side, and position 0 takes `tdi`.
- R4: When `capture_dr` is high at a rising edge, the cells load new values. Output-enable cells take `core_oe`, output cells take `core_out`, input cells take `pad_in` and the reset cell takes `rst_pin_in`. No pad or core-input value changes because of the capture.
- R5: The 3·NPAD update stages load the matching chain positions only when `update_dr` is high at a rising edge. Otherwise, including during capture and shift, they hold their value.
- R6: Mode values 00 (sample/preload) and 11 give the normal path: `pad_out`=`core_out`, `pad_oe`=`core_oe`, `core_in`=`pad_in`.
- R7: Mode 01 (external test) drives `pad_out` and `pad_oe` from the output and output-enable update stages, while `core_in` still follows `pad_in`.
- R8: Mode 10 (internal test) drives `core_in` from the input update stages, while `pad_out` and `pad_oe` still follow the core.
- R9: `rst_to_core` equals `rst_pin_in` in every mode. The reset cell has no update stage.
- R10: While `trst_n` is low, `mode_sel` is treated as normal regardless of its value.
- R11: With none of `capture_dr`, `shift_dr` or `update_dr` high, the chain holds its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, asynchronous, active low |
| tdi | input | 1 | Serial data in |
| capture_dr | input | 1 | Capture-DR state active |
| shift_dr | input | 1 | Shift-DR state active |
| update_dr | input | 1 | Update-DR state active |
| mode_sel | input | 2 | 00 sample/preload, 01 external test, 10 internal test, 11 normal |
| core_out | input | NPAD | Core output values |
| core_oe | input | NPAD | Core output enables |
| core_in | output | NPAD | Values delivered to the core inputs |
| pad_in | input | NPAD | Values arriving from the pads |
| pad_out | output | NPAD | Values driven to the pads |
| pad_oe | output | NPAD | Output enables driven to the pads |
| rst_pin_in | input | 1 | External reset pin level |
| rst_to_core | output | 1 | Reset delivered to the core |
| tdo | output | 1 | Serial data out |

## Verification
The assertions assume that at most one of `capture_dr`, `shift_dr` and `update_dr` is high in any cycle, as a TAP controller guarantees, and one property checks that assumption. The stimulus sets these three controls through a single task that raises at most one of them. It changes every data input only on the falling `tck` edge, so each rising edge sees stable values. The core and pad values are random in every cycle, which shows whether a capture, a shift or a test mode picked up the wrong source.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    typedef enum logic [1:0] {
        MODE_SAMPLE = 2'b00,
        MODE_EXTEST = 2'b01,
        MODE_INTEST = 2'b10,
        MODE_NORMAL = 2'b11
    } bs_mode_e;

    // Position of each cell kind of pad k, counted from the tdi end
    function automatic int unsigned pos_oe(input int unsigned k);
        return 3 * k;
    endfunction

    function automatic int unsigned pos_out(input int unsigned k);
        return 3 * k + 1;
    endfunction

    function automatic int unsigned pos_in(input int unsigned k);
        return 3 * k + 2;
    endfunction

endpackage

// File: rtl/bscan_shift_chain.sv
module bscan_shift_chain
    import bscan_pkg::*;
#(
    parameter int unsigned NPAD = 8,
    localparam int unsigned LEN = 3 * NPAD + 1
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  logic            capture_dr,
    input  logic            shift_dr,
    input  logic [NPAD-1:0] core_oe,
    input  logic [NPAD-1:0] core_out,
    input  logic [NPAD-1:0] pad_in,
    input  logic            rst_pin_in,
    output logic [LEN-1:0]  chain_o,
    output logic            tdo
);

    typedef struct packed {
        logic [LEN-1:0] cells;
    } chain_st_t;

    chain_st_t      st_d, st_q;
    logic [LEN-1:0] cap_vec;

    // Values loaded on capture, by cell kind
    for (genvar k = 0; k < NPAD; k++) begin : g_cap
        assign cap_vec[pos_oe(k)]  = core_oe[k];
        assign cap_vec[pos_out(k)] = core_out[k];
        assign cap_vec[pos_in(k)]  = pad_in[k];
    end
    assign cap_vec[LEN-1] = rst_pin_in;

    always_comb begin
        st_d = st_q;
        if (capture_dr) begin
            st_d.cells = cap_vec;
        end else if (shift_dr) begin
            st_d.cells = {st_q.cells[LEN-2:0], tdi};
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chain_o = st_q.cells;
    assign tdo     = st_q.cells[LEN-1];

    // R3: a shift moves tdi in and pushes the neighbour toward tdo
    p_shift_move_r3: assert property (@(posedge tck) disable iff (!trst_n)
        (shift_dr && !capture_dr) |=>
            (chain_o[0] == $past(tdi)) && (tdo == $past(chain_o[LEN-2])));

    // R11: no capture or shift means the chain stands still
    p_chain_hold_r11: assert property (@(posedge tck) disable iff (!trst_n)
        (!shift_dr && !capture_dr) |=> $stable(chain_o));

endmodule

// File: rtl/bscan_update_bank.sv
module bscan_update_bank #(
    parameter int unsigned NCELL = 24
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             update_dr,
    input  logic [NCELL-1:0] shift_bits,
    output logic [NCELL-1:0] upd_o
);

    typedef struct packed {
        logic [NCELL-1:0] hold;
    } upd_st_t;

    upd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (update_dr) begin
            st_d.hold = shift_bits;
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign upd_o = st_q.hold;

    // R5: held values change only through Update-DR
    p_upd_hold_r5: assert property (@(posedge tck) disable iff (!trst_n)
        !update_dr |=> $stable(upd_o));

    // R5: an update copies what the chain held at that edge
    p_upd_load_r5: assert property (@(posedge tck) disable iff (!trst_n)
        update_dr |=> (upd_o == $past(shift_bits)));

endmodule

// File: rtl/bscan_pad_mux.sv
module bscan_pad_mux
    import bscan_pkg::*;
#(
    parameter int unsigned NPAD = 8,
    localparam int unsigned NCELL = 3 * NPAD
) (
    input  bs_mode_e         mode,
    input  logic [NCELL-1:0] upd,
    input  logic [NPAD-1:0]  core_out,
    input  logic [NPAD-1:0]  core_oe,
    input  logic [NPAD-1:0]  pad_in,
    output logic [NPAD-1:0]  pad_out,
    output logic [NPAD-1:0]  pad_oe,
    output logic [NPAD-1:0]  core_in
);

    logic drive_pads_d;
    logic drive_core_d;

    always_comb begin
        drive_pads_d = (mode == MODE_EXTEST);
        drive_core_d = (mode == MODE_INTEST);
    end

    for (genvar k = 0; k < NPAD; k++) begin : g_pad
        assign pad_oe[k]  = drive_pads_d ? upd[pos_oe(k)]  : core_oe[k];
        assign pad_out[k] = drive_pads_d ? upd[pos_out(k)] : core_out[k];
        assign core_in[k] = drive_core_d ? upd[pos_in(k)]  : pad_in[k];
    end

endmodule

// File: rtl/bscan_chain_top.sv
module bscan_chain_top
    import bscan_pkg::*;
#(
    parameter int unsigned NPAD = 8,
    localparam int unsigned NCELL = 3 * NPAD,
    localparam int unsigned LEN = NCELL + 1
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  logic            capture_dr,
    input  logic            shift_dr,
    input  logic            update_dr,
    input  logic [1:0]      mode_sel,
    input  logic [NPAD-1:0] core_out,
    input  logic [NPAD-1:0] core_oe,
    output logic [NPAD-1:0] core_in,
    input  logic [NPAD-1:0] pad_in,
    output logic [NPAD-1:0] pad_out,
    output logic [NPAD-1:0] pad_oe,
    input  logic            rst_pin_in,
    output logic            rst_to_core,
    output logic            tdo
);

    logic [LEN-1:0]   chain_q;
    logic [NCELL-1:0] upd_q;
    bs_mode_e         mode_d;

    // R10: test reset forces the normal path
    always_comb begin
        mode_d = trst_n ? bs_mode_e'(mode_sel) : MODE_SAMPLE;
    end

    bscan_shift_chain #(.NPAD(NPAD)) u_chain (
        .tck        (tck),
        .trst_n     (trst_n),
        .tdi        (tdi),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .core_oe    (core_oe),
        .core_out   (core_out),
        .pad_in     (pad_in),
        .rst_pin_in (rst_pin_in),
        .chain_o    (chain_q),
        .tdo        (tdo)
    );

    // The reset cell (top position) has no update stage
    bscan_update_bank #(.NCELL(NCELL)) u_upd (
        .tck        (tck),
        .trst_n     (trst_n),
        .update_dr  (update_dr),
        .shift_bits (chain_q[NCELL-1:0]),
        .upd_o      (upd_q)
    );

    bscan_pad_mux #(.NPAD(NPAD)) u_mux (
        .mode     (mode_d),
        .upd      (upd_q),
        .core_out (core_out),
        .core_oe  (core_oe),
        .pad_in   (pad_in),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .core_in  (core_in)
    );

    // R9: the reset pin is observed, never overridden
    assign rst_to_core = rst_pin_in;

    // Input assumption: TAP states are exclusive
    p_ctrl_onehot: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({capture_dr, shift_dr, update_dr}));

    // R4: the reset cell sits next to tdo and captures the pin
    p_rst_capture_r4: assert property (@(posedge tck) disable iff (!trst_n)
        capture_dr |=> (tdo == $past(rst_pin_in)));

    // R6: normal modes give the core the pads
    p_normal_path_r6: assert property (@(posedge tck) disable iff (!trst_n)
        (mode_sel == 2'b00 || mode_sel == 2'b11) |->
            (pad_out == core_out && pad_oe == core_oe && core_in == pad_in));

    // R7: external test leaves the core inputs on the pads
    p_extest_core_r7: assert property (@(posedge tck) disable iff (!trst_n)
        (mode_sel == 2'b01) |-> (core_in == pad_in));

    // R8: internal test leaves the pads with the core
    p_intest_pads_r8: assert property (@(posedge tck) disable iff (!trst_n)
        (mode_sel == 2'b10) |-> (pad_out == core_out && pad_oe == core_oe));

endmodule

// File: tb/bscan_chain_top_test.sv
`timescale 1ns/1ps
module bscan_chain_top_test;

    localparam int NPAD  = 8;
    localparam int NCELL = 3 * NPAD;
    localparam int LEN   = NCELL + 1;

    logic            tck = 1'b0;
    logic            trst_n = 1'b0;
    logic            tdi = 1'b0;
    logic            capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
    logic [1:0]      mode_sel = 2'b00;
    logic [NPAD-1:0] core_out = '0, core_oe = '0, pad_in = '0;
    logic [NPAD-1:0] core_in, pad_out, pad_oe;
    logic            rst_pin_in = 1'b1;
    logic            rst_to_core, tdo;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;
    string cur_req  = "R1";

    // Reference state: chain as a queue, index 0 at the tdi end
    bit m_chain[$];
    bit m_upd[NCELL];

    always #10 tck = ~tck;

    bscan_chain_top #(.NPAD(NPAD)) uut (
        .tck(tck), .trst_n(trst_n), .tdi(tdi),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .mode_sel(mode_sel), .core_out(core_out), .core_oe(core_oe),
        .core_in(core_in), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .rst_pin_in(rst_pin_in), .rst_to_core(rst_to_core), .tdo(tdo)
    );

    task automatic model_clear();
        m_chain.delete();
        for (int i = 0; i < LEN; i++) m_chain.push_back(1'b0);
        for (int i = 0; i < NCELL; i++) m_upd[i] = 1'b0;
    endtask

    initial model_clear();

    always @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            model_clear();
        end else if (capture_dr) begin
            for (int k = 0; k < NPAD; k++) begin
                m_chain[3*k]   = core_oe[k];
                m_chain[3*k+1] = core_out[k];
                m_chain[3*k+2] = pad_in[k];
            end
            m_chain[LEN-1] = rst_pin_in;
        end else if (shift_dr) begin
            m_chain.push_front(tdi);
            void'(m_chain.pop_back());
        end else if (update_dr) begin
            for (int i = 0; i < NCELL; i++) m_upd[i] = m_chain[i];
        end
    end

    task automatic check(input string what, input logic [NPAD-1:0] act, input logic [NPAD-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [NPAD-1:0] e_out, e_oe, e_in;
        logic [1:0] m;
        m = trst_n ? mode_sel : 2'b00;
        for (int k = 0; k < NPAD; k++) begin
            e_oe[k]  = (m == 2'b01) ? m_upd[3*k]   : core_oe[k];
            e_out[k] = (m == 2'b01) ? m_upd[3*k+1] : core_out[k];
            e_in[k]  = (m == 2'b10) ? m_upd[3*k+2] : pad_in[k];
        end
        check("pad_out", pad_out, e_out);
        check("pad_oe", pad_oe, e_oe);
        check("core_in", core_in, e_in);
        check("tdo", {{(NPAD-1){1'b0}}, tdo}, {{(NPAD-1){1'b0}}, m_chain[LEN-1]});
        check("rst_to_core", {{(NPAD-1){1'b0}}, rst_to_core}, {{(NPAD-1){1'b0}}, rst_pin_in});
    endtask

    // One cycle: at most one control high, data inputs randomized
    task automatic cyc(input bit cap, input bit sh, input bit upd, input bit din);
        @(negedge tck);
        compare();
        capture_dr = cap;
        shift_dr   = sh;
        update_dr  = upd;
        tdi        = din;
        core_out   = NPAD'($urandom);
        core_oe    = NPAD'($urandom);
        pad_in     = NPAD'($urandom);
        #1 compare();
    endtask

    task automatic shift_n(input int n);
        for (int i = 0; i < n; i++) cyc(0, 1, 0, 1'($urandom));
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1, R10: reset state with a test mode requested
        cur_req = "R10";
        mode_sel = 2'b01;
        for (int i = 0; i < 3; i++) cyc(0, 1, 0, 1'b1);
        cur_req = "R1";
        check("tdo reset", {{(NPAD-1){1'b0}}, tdo}, '0);
        @(negedge tck);
        trst_n = 1'b1;
        mode_sel = 2'b00;

        // R4: capture then R2, R3: shift the full chain out
        for (int r = 0; r < 4; r++) begin
            cur_req = "R4";
            rst_pin_in = r[0];
            cyc(1, 0, 0, 0);
            cur_req = "R2";
            cyc(0, 0, 0, 0);
            cur_req = "R3";
            shift_n(LEN);
            cur_req = "R5";
            cyc(0, 0, 1, 0);
            cur_req = "R11";
            for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1);
        end

        // R7: external test, shifting meanwhile must not disturb pads (R5)
        cur_req = "R7";
        mode_sel = 2'b01;
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0);
        cur_req = "R5";
        cyc(1, 0, 0, 0);
        shift_n(10);
        cur_req = "R7";
        cyc(0, 0, 1, 0);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0);

        // R8: internal test from the same preload
        cur_req = "R8";
        mode_sel = 2'b10;
        shift_n(LEN);
        cyc(0, 0, 1, 0);
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0);

        // R6: reserved and sample modes
        cur_req = "R6";
        mode_sel = 2'b11;
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0);
        mode_sel = 2'b00;
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0);

        // R9: reset pin passes through in every mode
        cur_req = "R9";
        for (int m = 0; m < 4; m++) begin
            mode_sel = 2'(m);
            rst_pin_in = 1'b0;
            cyc(1, 0, 0, 0);
            rst_pin_in = 1'b1;
            cyc(0, 0, 0, 0);
        end

        // R1: mid-run reset clears update stages
        cur_req = "R1";
        mode_sel = 2'b01;
        @(negedge tck);
        trst_n = 1'b0;
        cyc(0, 0, 0, 0);
        @(negedge tck);
        trst_n = 1'b1;
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0);

        @(negedge tck);
        compare();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule